// File: doc/BRIEF.md
# Serial Transmitter with Automatic Clear-to-Send Gating

This block serializes bytes onto an asynchronous line as 8N1 frames. A frame is one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts `OVS` pulses of an external oversampling tick. Bytes arrive on a valid/ready handshake. The block holds one byte at a time and lowers `tx_ready` while that byte is on the line.

When `flow_en` is set, an active-low clear-to-send input (`cts_n`) decides whether the next character may start. The input first passes through a two-flop synchronizer. The decision is taken only at a character boundary, so a character that has begun always completes through its stop bit. While `cts_n` is high, the line stays idle and `tx_ready` stays low. The pending byte goes out as soon as `cts_n` returns low.

A rising edge of the synchronized `cts_n` can raise a sticky interrupt flag. The flag is readable as bit 5 of `stat_code` and is cleared by a read strobe.

Top module: `cts_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `irq` is 0, `stat_code` is 8'h00, and `tx_ready` is 1 when `flow_en` is 0.
- R2: An accepted byte goes out as a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts `OVS` tick pulses, and the line is high between frames.
- R3: A byte is taken only on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that edge until the stop bit ends, and bytes offered back to back go out in order.
- R4: With `flow_en` at 0, `cts_n` has no effect on `tx_ready` or on the frames sent.
- R5: With `flow_en` at 1, a synchronized `cts_n` of 1 at a character boundary keeps `txd` at 1 and `tx_ready` at 0, and no new character starts.
- R6: A rise of `cts_n` while a character is on the line does not shorten it: all ten bits, including the stop bit, are sent unchanged.
- R7: Once `cts_n` returns to 0 with `flow_en` at 1, the pending byte is sent without any other action.
- R8: When `ext_en` and `cts_ie` are both 1, a 0-to-1 change of the synchronized `cts_n` sets the interrupt flag. The flag drives `irq` to 1 and `stat_code` to 8'h20 (bit 5 set, all other bits 0). With either enable at 0, no flag is set.
- R9: The flag stays set until a cycle with `stat_rd` at 1 clears it; a new set in the same cycle wins. A 1-to-0 change of `cts_n` never sets it.
- R10: `cts_n` takes effect through two flops: on a change at the input, `tx_ready` reacts at the second rising clock edge, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling pulse, OVS per bit |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte may be taken this cycle |
| txd | output | 1 | Serial line, idle high |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| flow_en | input | 1 | Gate character starts on `cts_n` |
| ext_en | input | 1 | Extended features enable for the interrupt |
| cts_ie | input | 1 | Interrupt enable for `cts_n` deassertion |
| irq | output | 1 | Interrupt request (sticky flag) |
| stat_code | output | 8 | Interrupt status, bit 5 = `cts_n` deasserted |
| stat_rd | input | 1 | Status read strobe, clears the flag |

## Verification
The bench builds the block with `OVS` = 4 and drives a tick on every other clock, so one bit spans eight clocks and a whole frame eighty. This makes many frames, as well as long suspended stretches, affordable within one run. The tick rate slower than the clock exercises the tick gating and the boundary phase offset. The short frame lets the bench raise `cts_n` well inside a character and still watch the following byte being held back and then released.

// File: rtl/cts_uart_tx.sv
module cts_uart_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          txd,
  input  logic          cts_n,
  input  logic          flow_en,
  input  logic          ext_en,
  input  logic          cts_ie,
  output logic          irq,
  output logic [7:0]    stat_code,
  input  logic          stat_rd
);
  localparam int FW = DW + 2;
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic          busy;
  logic          cts_s1, cts_s2, cts_q;
  logic          flag;
  logic          cts_rise;

  assign cts_rise  = cts_s2 & ~cts_q;
  assign tx_ready  = ~busy & ~(flow_en & cts_s2);
  assign txd       = busy ? sh[0] : 1'b1;
  assign irq       = flag;
  assign stat_code = {2'b00, flag, 5'b00000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1 <= 1'b0;
      cts_s2 <= 1'b0;
      cts_q  <= 1'b0;
    end else begin
      cts_s1 <= cts_n;
      cts_s2 <= cts_s1;
      cts_q  <= cts_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (cts_rise && cts_ie && ext_en) flag <= 1'b1;
    else if (stat_rd) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      tcnt <= '0;
      bcnt <= '0;
    end else if (tx_valid && tx_ready) begin
      busy <= 1'b1;
      sh   <= {1'b1, tx_data, 1'b0};
      tcnt <= '0;
      bcnt <= '0;
    end else if (busy && tick) begin
      if (tcnt == TW'(OVS - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        if (bcnt == BW'(FW - 1)) busy <= 1'b0;
        else bcnt <= bcnt + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bcnt) == BW'(FW - 1) && $past(tcnt) == TW'(OVS - 1)));
  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && cts_s2 && !busy) |=> !busy);
  a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_rise && cts_ie && ext_en) |=> irq);
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd) |=> irq);
endmodule

// File: tb/cts_uart_tx_tb.sv
module cts_uart_tx_tb;
  localparam int CLK_NS = 10;
  localparam int OVS    = 4;
  localparam int TDIV   = 2;
  localparam int BITC   = OVS * TDIV;
  localparam int HALF   = BITC / 2;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, cts_n = 0, flow_en = 0, ext_en = 0, cts_ie = 0, stat_rd = 0;
  logic tx_ready, txd, irq;
  logic [7:0] stat_code;

  int total = 0, fails = 0, rx_cnt = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #(CLK_NS/2) clk = ~clk;

  cts_uart_tx #(.OVS(OVS), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .cts_n(cts_n), .flow_en(flow_en), .ext_en(ext_en),
    .cts_ie(cts_ie), .irq(irq), .stat_code(stat_code), .stat_rd(stat_rd));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic send(input logic [7:0] b);
    expq.push_back(b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 3000 && rx_cnt < n; i++) @(negedge clk);
  endtask

  // monitor: decode frames and compare against the scoreboard queue
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] got;
        cyc(HALF);
        chk(txd === 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          cyc(BITC);
          got[i] = txd;
        end
        cyc(BITC);
        chk(txd === 1'b1, "R2/R6 stop bit", txd, 1);
        if (expq.size() == 0) chk(0, "R3 unexpected byte", got, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(got === e, "R2 data byte", got, e);
        end
        rx_cnt++;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    cyc(4);
    rst_n = 1;
    cyc(1);
    chk(txd === 1'b1, "R1 txd idle", txd, 1);
    chk(tx_ready === 1'b1, "R1 ready", tx_ready, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(stat_code === 8'h00, "R1 status", stat_code, 0);

    // R4: CTS deasserted but gating off
    cts_n = 1;
    cyc(4);
    send(8'hA5);
    chk(tx_ready === 1'b0, "R3 ready low while shifting", tx_ready, 0);
    send(8'h3C);
    send(8'h01);
    send(8'h80);
    wait_rx(4);
    chk(rx_cnt == 4, "R4 frames sent with cts_n high", rx_cnt, 4);

    // R10 / R5 / R7
    cts_n = 0;
    cyc(6);
    flow_en = 1;
    cyc(1);
    chk(tx_ready === 1'b1, "R7 ready with cts low", tx_ready, 1);
    cts_n = 1;
    cyc(1);
    chk(tx_ready === 1'b1, "R10 first edge no effect", tx_ready, 1);
    cyc(1);
    chk(tx_ready === 1'b0, "R10 second edge gates", tx_ready, 0);
    base = rx_cnt;
    fork send(8'h5A); join_none
    cyc(150);
    chk(rx_cnt == base, "R5 no character while suspended", rx_cnt, base);
    chk(txd === 1'b1, "R5 line idle while suspended", txd, 1);
    chk(tx_ready === 1'b0, "R5 ready low while suspended", tx_ready, 0);
    cts_n = 0;
    wait_rx(base + 1);
    chk(rx_cnt == base + 1, "R7 resumed after cts low", rx_cnt, base + 1);

    // R6: deassert mid-character
    cyc(20);
    base = rx_cnt;
    fork begin send(8'hC3); send(8'h96); end join_none
    cyc(1);
    while (tx_ready) @(negedge clk);
    cyc(20);
    cts_n = 1;
    cyc(200);
    chk(rx_cnt == base + 1, "R6 character completed, next held", rx_cnt, base + 1);
    chk(tx_ready === 1'b0, "R5 held byte not taken", tx_ready, 0);
    cts_n = 0;
    wait_rx(base + 2);
    chk(rx_cnt == base + 2, "R7 held byte sent", rx_cnt, base + 2);

    // R8 / R9 interrupt
    flow_en = 0;
    ext_en = 1;
    cts_ie = 1;
    cyc(6);
    chk(irq === 1'b0, "R9 no irq before rise", irq, 0);
    cts_n = 1;
    cyc(4);
    chk(irq === 1'b1, "R8 irq on rise", irq, 1);
    chk(stat_code === 8'h20, "R8 status code", stat_code, 8'h20);
    cyc(10);
    chk(irq === 1'b1, "R9 flag holds", irq, 1);
    stat_rd = 1;
    cyc(1);
    stat_rd = 0;
    chk(irq === 1'b0, "R9 read clears", irq, 0);
    chk(stat_code === 8'h00, "R9 status cleared", stat_code, 0);
    cts_n = 0;
    cyc(6);
    chk(irq === 1'b0, "R9 falling edge no irq", irq, 0);
    cts_ie = 0;
    cts_n = 1;
    cyc(6);
    chk(irq === 1'b0, "R8 no irq when cts_ie low", irq, 0);
    cts_n = 0;
    cts_ie = 1;
    ext_en = 0;
    cyc(6);
    cts_n = 1;
    cyc(6);
    chk(irq === 1'b0, "R8 no irq when ext_en low", irq, 0);

    cyc(20);
    chk(expq.size() == 0, "R3 all bytes delivered", expq.size(), 0);
    finish_run();
  end
endmodule